// File: doc/BRIEF.md
# Line-Replay Video Source

This block is a video test-pattern generator fed from external memory. Software writes the physical address of a pixel buffer, a line count and a start command through an AXI4-Lite register file. For every output line the block fetches one full line of 640 words from that buffer with AXI4 burst reads, keeps the low 16 bits of each word in a local line buffer, and then plays the line out as an AXI4-Stream video line. Because the buffer address never moves, each line of a frame carries the same content, which gives a known and software-changeable picture for checking downstream video processing.

The stream marks the first pixel of a frame on TUSER and the last pixel of each line on TLAST. A frame can be run once, or repeated back to back with auto-restart until software clears it. Status bits in the control register report whether the block is idle and whether a frame has finished since the last status read.

Top module: `video_line_replay`

## Requirements
- R1: After a start with a line count N greater than 0, the stream delivers exactly N×640 beats, after which the block returns to idle and the done status is set.
- R2: Each line is fetched as three AXI4 read bursts with ARLEN 255, 255 and 127 (256, 256 and 128 beats), ARSIZE 2 (4 bytes) and ARBURST 1 (incrementing), at byte addresses base, base+1024 and base+2048; AR signals hold steady while ARVALID waits for ARREADY.
- R3: Every line of every frame is fetched from the same programmed base address; the address is never advanced between lines.
- R4: The TDATA of column k of a line equals bits 15:0 of the 32-bit word read from byte address base+4k.
- R5: TUSER is 1 on the first beat of each frame (line 0, column 0) and 0 on every other beat.
- R6: TLAST is 1 on column 639 of every line and 0 on all other beats.
- R7: While TVALID is 1 and TREADY is 0, TVALID stays 1 and TDATA, TUSER and TLAST do not change.
- R8: No beat of a line is presented on the stream before all 640 words of that line have been received from memory.
- R9: The line-count register at offset 0x10 and the base-address register at offset 0x18 read back the values last written to them.
- R10: Control register (offset 0x00) reads return bit 2 = idle, bit 1 = done, bit 7 = auto-restart and bit 0 = busy; after reset it reads 0x04. Done is set when a frame completes and is cleared by the read that returns it.
- R11: Writing 0x81 to the control register starts frames that follow each other with no gap in the stream; writing 0x00 while running lets the current frame finish and then no further reads or beats occur.
- R12: A start with a line count of 0 issues no memory read and no stream beat, and sets done at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_axil_awaddr | input | REG_AW | Register write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | 32 | Register write data |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response, always OKAY |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | REG_AW | Register read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | 32 | Register read data |
| s_axil_rresp | output | 2 | Read response, always OKAY |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| m_axi_araddr | output | ADDR_W | Burst start byte address |
| m_axi_arlen | output | 8 | Burst length minus one |
| m_axi_arsize | output | 3 | Beat size code |
| m_axi_arburst | output | 2 | Burst type code |
| m_axi_arvalid | output | 1 | Read address valid |
| m_axi_arready | input | 1 | Read address ready |
| m_axi_rdata | input | DATA_W | Read data word |
| m_axi_rlast | input | 1 | Last beat of a burst |
| m_axi_rvalid | input | 1 | Read data valid |
| m_axi_rready | output | 1 | Read data ready |
| m_axis_tdata | output | PIX_W | Pixel value |
| m_axis_tuser | output | 1 | Start-of-frame marker |
| m_axis_tlast | output | 1 | End-of-line marker |
| m_axis_tvalid | output | 1 | Stream beat valid |
| m_axis_tready | input | 1 | Stream beat ready |

## Verification
On every cycle the assertions watch the handshake rules: stream signals frozen during back-pressure, AR signals held until accepted, register read data held until taken, no stream beat while the memory read channel is active, a line left only after its final beat, and each burst ending on RLAST inside the line's address window. Pixel values, sideband placement, burst lengths and addresses, the exact beat and burst totals of a frame, the done and idle status sequence, the stop behaviour of auto-restart and the empty frame can only be shown by the bench's scenarios, which compare every beat and every burst with values worked out from the address and a per-run seed.

// File: rtl/lr_pkg.sv
package lr_pkg;

    // Register offsets seen by software
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_LINES = 8'h10;
    localparam logic [7:0] OFS_BASE  = 8'h18;

    // Control register bit positions
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_DONE = 1;
    localparam int CTRL_IDLE = 2;
    localparam int CTRL_AUTO = 7;

    // AXI4 read-address encodings
    localparam logic [2:0] AXSIZE_4B  = 3'b010;
    localparam logic [1:0] AXBURST_INC = 2'b01;
    localparam int         AXLEN_W    = 8;

    typedef enum logic [1:0] {
        FT_IDLE = 2'd0,
        FT_ADDR = 2'd1,
        FT_DATA = 2'd2
    } fetch_state_e;

    typedef enum logic [1:0] {
        EN_IDLE  = 2'd0,
        EN_FETCH = 2'd1,
        EN_SEND  = 2'd2
    } eng_state_e;

endpackage

// File: rtl/lr_regs.sv
module lr_regs
    import lr_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [REG_AW-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic              idle_i,
    input  logic              frame_done_i,
    output logic              start_o,
    output logic              auto_o,
    output logic [CNT_W-1:0]  lines_o,
    output logic [ADDR_W-1:0] base_o
);

    typedef struct packed {
        logic              auto_en;
        logic              done;
        logic [CNT_W-1:0]  lines;
        logic [ADDR_W-1:0] base;
        logic              bvalid;
        logic              rvalid;
        logic [31:0]       rdata;
    } regs_t;

    regs_t q, d;
    logic  wr_fire, rd_fire, wr_ctrl;
    logic [31:0] rd_mux;

    always_comb begin
        d       = q;
        wr_fire = s_awvalid && s_wvalid && !q.bvalid;
        rd_fire = s_arvalid && !q.rvalid;
        wr_ctrl = wr_fire && (s_awaddr == REG_AW'(OFS_CTRL));
        start_o = wr_ctrl && s_wdata[CTRL_RUN];

        rd_mux = '0;
        if (s_araddr == REG_AW'(OFS_CTRL)) begin
            rd_mux[CTRL_RUN]  = !idle_i;
            rd_mux[CTRL_DONE] = q.done;
            rd_mux[CTRL_IDLE] = idle_i;
            rd_mux[CTRL_AUTO] = q.auto_en;
        end else if (s_araddr == REG_AW'(OFS_LINES)) begin
            rd_mux = 32'(q.lines);
        end else if (s_araddr == REG_AW'(OFS_BASE)) begin
            rd_mux = 32'(q.base);
        end

        if (q.bvalid && s_bready) d.bvalid = 1'b0;
        if (wr_fire) begin
            d.bvalid = 1'b1;
            if (wr_ctrl) begin
                d.auto_en = s_wdata[CTRL_AUTO];
                if (s_wdata[CTRL_RUN]) d.done = 1'b0;
            end else if (s_awaddr == REG_AW'(OFS_LINES)) begin
                d.lines = s_wdata[CNT_W-1:0];
            end else if (s_awaddr == REG_AW'(OFS_BASE)) begin
                d.base = s_wdata[ADDR_W-1:0];
            end
        end

        if (q.rvalid && s_rready) d.rvalid = 1'b0;
        if (rd_fire) begin
            d.rvalid = 1'b1;
            d.rdata  = rd_mux;
            if (s_araddr == REG_AW'(OFS_CTRL)) d.done = 1'b0;
        end

        // a completing frame wins over a clearing read in the same cycle
        if (frame_done_i) d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign s_awready = wr_fire;
    assign s_wready  = wr_fire;
    assign s_bvalid  = q.bvalid;
    assign s_arready = !q.rvalid;
    assign s_rvalid  = q.rvalid;
    assign s_rdata   = q.rdata;
    assign auto_o    = q.auto_en;
    assign lines_o   = q.lines;
    assign base_o    = q.base;

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

    // R10
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_i |=> q.done);

endmodule

// File: rtl/lr_fetch.sv
module lr_fetch
    import lr_pkg::*;
#(
    parameter int LINE_PIX  = 640,
    parameter int MAX_BURST = 256,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PIX_W     = 16,
    parameter int IDX_W     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [ADDR_W-1:0]  base_i,
    output logic [ADDR_W-1:0]  m_araddr,
    output logic [AXLEN_W-1:0] m_arlen,
    output logic               m_arvalid,
    input  logic               m_arready,
    input  logic [DATA_W-1:0]  m_rdata,
    input  logic               m_rlast,
    input  logic               m_rvalid,
    output logic               m_rready,
    output logic               wr_en_o,
    output logic [IDX_W-1:0]   wr_idx_o,
    output logic [PIX_W-1:0]   wr_data_o,
    output logic               done_o
);

    typedef struct packed {
        fetch_state_e       state;
        logic [IDX_W-1:0]   word;
        logic [AXLEN_W-1:0] beat;
        logic [AXLEN_W-1:0] blen;
    } fetch_t;

    fetch_t q, d;
    int     remain;
    logic [AXLEN_W-1:0] cur_len;

    always_comb begin
        d         = q;
        m_arvalid = 1'b0;
        m_rready  = 1'b0;
        wr_en_o   = 1'b0;
        wr_idx_o  = q.word;
        wr_data_o = m_rdata[PIX_W-1:0];
        done_o    = 1'b0;
        remain    = LINE_PIX - int'(q.word);
        cur_len   = (remain > MAX_BURST) ? AXLEN_W'(MAX_BURST - 1) : AXLEN_W'(remain - 1);

        case (q.state)
            FT_IDLE: begin
                if (go_i) begin
                    d.word  = '0;
                    d.state = FT_ADDR;
                end
            end
            FT_ADDR: begin
                m_arvalid = 1'b1;
                if (m_arready) begin
                    d.blen  = cur_len;
                    d.beat  = '0;
                    d.state = FT_DATA;
                end
            end
            FT_DATA: begin
                m_rready = 1'b1;
                if (m_rvalid) begin
                    wr_en_o = 1'b1;
                    d.word  = q.word + IDX_W'(1);
                    d.beat  = q.beat + AXLEN_W'(1);
                    if (q.beat == q.blen) begin
                        if (int'(q.word) == LINE_PIX - 1) begin
                            done_o  = 1'b1;
                            d.state = FT_IDLE;
                        end else begin
                            d.state = FT_ADDR;
                        end
                    end
                end
            end
            default: d.state = FT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: FT_IDLE, default: '0};
        else        q <= d;
    end

    assign m_araddr = base_i + (ADDR_W'(q.word) << 2);
    assign m_arlen  = cur_len;

    // R2
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));

    // R2
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid && m_rready && (q.beat == q.blen) |-> m_rlast);

    // R3
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && m_arready |->
            (m_araddr[1:0] == 2'b00) && ((m_araddr - base_i) < ADDR_W'(4 * LINE_PIX)));

endmodule

// File: rtl/lr_linebuf.sv
module lr_linebuf #(
    parameter int DEPTH = 640,
    parameter int W     = 16,
    parameter int IW    = 10
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/lr_engine.sv
module lr_engine
    import lr_pkg::*;
#(
    parameter int LINE_PIX = 640,
    parameter int CNT_W    = 16,
    parameter int IDX_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             auto_i,
    input  logic [CNT_W-1:0] lines_i,
    input  logic             fetch_done_i,
    output logic             fetch_go_o,
    output logic             frame_done_o,
    output logic             idle_o,
    output logic [IDX_W-1:0] col_o,
    output logic             tvalid_o,
    output logic             tuser_o,
    output logic             tlast_o,
    input  logic             tready_i
);

    localparam logic [IDX_W-1:0] LAST_COL = IDX_W'(LINE_PIX - 1);

    typedef struct packed {
        eng_state_e       state;
        logic [IDX_W-1:0] col;
        logic [CNT_W-1:0] line;
        logic [CNT_W-1:0] nlines;
        logic             fdone;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d          = q;
        d.fdone    = 1'b0;
        fetch_go_o = 1'b0;
        tvalid_o   = 1'b0;

        case (q.state)
            EN_IDLE: begin
                if (start_i) begin
                    if (lines_i == '0) begin
                        d.fdone = 1'b1;
                    end else begin
                        d.nlines   = lines_i;
                        d.line     = '0;
                        d.state    = EN_FETCH;
                        fetch_go_o = 1'b1;
                    end
                end
            end
            EN_FETCH: begin
                if (fetch_done_i) begin
                    d.col   = '0;
                    d.state = EN_SEND;
                end
            end
            EN_SEND: begin
                tvalid_o = 1'b1;
                if (tready_i) begin
                    if (q.col != LAST_COL) begin
                        d.col = q.col + IDX_W'(1);
                    end else if (q.line != q.nlines - CNT_W'(1)) begin
                        d.line     = q.line + CNT_W'(1);
                        d.state    = EN_FETCH;
                        fetch_go_o = 1'b1;
                    end else begin
                        d.fdone = 1'b1;
                        if (auto_i && (lines_i != '0)) begin
                            d.nlines   = lines_i;
                            d.line     = '0;
                            d.state    = EN_FETCH;
                            fetch_go_o = 1'b1;
                        end else begin
                            d.state = EN_IDLE;
                        end
                    end
                end
            end
            default: d.state = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: EN_IDLE, default: '0};
        else        q <= d;
    end

    assign tuser_o      = (q.line == '0) && (q.col == '0);
    assign tlast_o      = (q.col == LAST_COL);
    assign col_o        = q.col;
    assign idle_o       = (q.state == EN_IDLE);
    assign frame_done_o = q.fdone;

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tvalid_o && !tready_i |=> tvalid_o && $stable(tuser_o) && $stable(tlast_o) && $stable(col_o));

    // R1
    line_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == EN_SEND) && !(tready_i && tlast_o) |=> (q.state == EN_SEND));

    // R1
    line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != EN_IDLE) |-> (q.line < q.nlines));

endmodule

// File: rtl/video_line_replay.sv
module video_line_replay
    import lr_pkg::*;
#(
    parameter int REG_AW    = 8,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int PIX_W     = 16,
    parameter int LINE_PIX  = 640,
    parameter int MAX_BURST = 256,
    parameter int CNT_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  s_axil_awaddr,
    input  logic               s_axil_awvalid,
    output logic               s_axil_awready,
    input  logic [31:0]        s_axil_wdata,
    input  logic               s_axil_wvalid,
    output logic               s_axil_wready,
    output logic [1:0]         s_axil_bresp,
    output logic               s_axil_bvalid,
    input  logic               s_axil_bready,
    input  logic [REG_AW-1:0]  s_axil_araddr,
    input  logic               s_axil_arvalid,
    output logic               s_axil_arready,
    output logic [31:0]        s_axil_rdata,
    output logic [1:0]         s_axil_rresp,
    output logic               s_axil_rvalid,
    input  logic               s_axil_rready,
    output logic [ADDR_W-1:0]  m_axi_araddr,
    output logic [7:0]         m_axi_arlen,
    output logic [2:0]         m_axi_arsize,
    output logic [1:0]         m_axi_arburst,
    output logic               m_axi_arvalid,
    input  logic               m_axi_arready,
    input  logic [DATA_W-1:0]  m_axi_rdata,
    input  logic               m_axi_rlast,
    input  logic               m_axi_rvalid,
    output logic               m_axi_rready,
    output logic [PIX_W-1:0]   m_axis_tdata,
    output logic               m_axis_tuser,
    output logic               m_axis_tlast,
    output logic               m_axis_tvalid,
    input  logic               m_axis_tready
);

    localparam int IDX_W = $clog2(LINE_PIX + 1);

    logic               start, auto_en, idle, frame_done;
    logic [CNT_W-1:0]   lines;
    logic [ADDR_W-1:0]  base;
    logic               fetch_go, fetch_done;
    logic               buf_we;
    logic [IDX_W-1:0]   buf_widx, col;
    logic [PIX_W-1:0]   buf_wdata;
    logic               unused_hi;

    assign unused_hi     = ^m_axi_rdata[DATA_W-1:PIX_W];
    assign s_axil_bresp  = 2'b00;
    assign s_axil_rresp  = 2'b00;
    assign m_axi_arsize  = AXSIZE_4B;
    assign m_axi_arburst = AXBURST_INC;

    lr_regs #(.REG_AW(REG_AW), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_axil_awaddr), .s_awvalid(s_axil_awvalid), .s_awready(s_axil_awready),
        .s_wdata(s_axil_wdata), .s_wvalid(s_axil_wvalid), .s_wready(s_axil_wready),
        .s_bvalid(s_axil_bvalid), .s_bready(s_axil_bready),
        .s_araddr(s_axil_araddr), .s_arvalid(s_axil_arvalid), .s_arready(s_axil_arready),
        .s_rdata(s_axil_rdata), .s_rvalid(s_axil_rvalid), .s_rready(s_axil_rready),
        .idle_i(idle), .frame_done_i(frame_done),
        .start_o(start), .auto_o(auto_en), .lines_o(lines), .base_o(base)
    );

    lr_fetch #(
        .LINE_PIX(LINE_PIX), .MAX_BURST(MAX_BURST), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .PIX_W(PIX_W), .IDX_W(IDX_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .go_i(fetch_go), .base_i(base),
        .m_araddr(m_axi_araddr), .m_arlen(m_axi_arlen),
        .m_arvalid(m_axi_arvalid), .m_arready(m_axi_arready),
        .m_rdata(m_axi_rdata), .m_rlast(m_axi_rlast),
        .m_rvalid(m_axi_rvalid), .m_rready(m_axi_rready),
        .wr_en_o(buf_we), .wr_idx_o(buf_widx), .wr_data_o(buf_wdata),
        .done_o(fetch_done)
    );

    lr_linebuf #(.DEPTH(LINE_PIX), .W(PIX_W), .IW(IDX_W)) u_buf (
        .clk(clk), .wr_en(buf_we), .wr_idx(buf_widx), .wr_data(buf_wdata),
        .rd_idx(col), .rd_data(m_axis_tdata)
    );

    lr_engine #(.LINE_PIX(LINE_PIX), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .auto_i(auto_en), .lines_i(lines),
        .fetch_done_i(fetch_done), .fetch_go_o(fetch_go),
        .frame_done_o(frame_done), .idle_o(idle), .col_o(col),
        .tvalid_o(m_axis_tvalid), .tuser_o(m_axis_tuser), .tlast_o(m_axis_tlast),
        .tready_i(m_axis_tready)
    );

    // R8
    no_early_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_axi_rready |-> !m_axis_tvalid);

    // R7
    pixel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_axis_tvalid && !m_axis_tready |=> $stable(m_axis_tdata));

endmodule

// File: tb/video_line_replay_test.sv
module video_line_replay_test;

    localparam int LP = 640;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic [31:0] wdata = '0;
    logic        awready, wready, bvalid, arready_l, rvalid_l;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata_l;
    logic [31:0] m_araddr;
    logic [7:0]  m_arlen;
    logic [2:0]  m_arsize;
    logic [1:0]  m_arburst;
    logic        m_arvalid, m_rready;
    logic        m_arready = 1'b0, m_rvalid = 1'b0, m_rlast = 1'b0;
    logic [31:0] m_rdata = '0;
    logic [15:0] tdata;
    logic        tuser, tlast, tvalid;
    logic        tready = 1'b0;

    always #10 clk = ~clk;

    video_line_replay uut (
        .clk(clk), .rst_n(rst_n),
        .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
        .s_axil_wdata(wdata), .s_axil_wvalid(wvalid), .s_axil_wready(wready),
        .s_axil_bresp(bresp), .s_axil_bvalid(bvalid), .s_axil_bready(1'b1),
        .s_axil_araddr(araddr), .s_axil_arvalid(arvalid), .s_axil_arready(arready_l),
        .s_axil_rdata(rdata_l), .s_axil_rresp(rresp), .s_axil_rvalid(rvalid_l),
        .s_axil_rready(1'b1),
        .m_axi_araddr(m_araddr), .m_axi_arlen(m_arlen), .m_axi_arsize(m_arsize),
        .m_axi_arburst(m_arburst), .m_axi_arvalid(m_arvalid), .m_axi_arready(m_arready),
        .m_axi_rdata(m_rdata), .m_axi_rlast(m_rlast), .m_axi_rvalid(m_rvalid),
        .m_axi_rready(m_rready),
        .m_axis_tdata(tdata), .m_axis_tuser(tuser), .m_axis_tlast(tlast),
        .m_axis_tvalid(tvalid), .m_axis_tready(tready)
    );

    int errors = 0, checks = 0;
    int beats = 0, rbeats = 0, bursts = 0;
    int exp_lines = 1, tmode = 0, cyc = 0;
    logic [31:0] exp_base = '0;
    logic [15:0] seed = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pix(input logic [31:0] byte_addr);
        return 16'((byte_addr >> 2) * 7) + seed;
    endfunction

    // memory responder and stream sink, both driven at the falling edge
    initial begin : sink
        int          rem_beats = 0;
        logic [31:0] cur = '0;
        bit          stalled = 0;
        logic [17:0] held = '0;
        forever begin
            @(negedge clk);
            cyc++;
            // R channel first, so data never precedes its address handshake
            if (rem_beats > 0 && (cyc % 5 != 3)) begin
                m_rvalid = 1'b1;
                m_rdata  = {16'hC3A5, pix(cur)};
                m_rlast  = (rem_beats == 1);
                if (m_rready) begin
                    cur += 4;
                    rem_beats--;
                    rbeats++;
                end
            end else begin
                m_rvalid = 1'b0;
                m_rlast  = 1'b0;
            end
            if (rem_beats == 0) begin
                m_arready = (cyc % 4 != 1);
                if (m_arvalid && m_arready) begin
                    int bi;
                    bi = bursts % 3;
                    // R2 / R3: burst shape and fixed base
                    chk(m_araddr == exp_base + 32'(bi * 1024), "R3 araddr", m_araddr, exp_base + 32'(bi * 1024));
                    chk(m_arlen == ((bi == 2) ? 8'd127 : 8'd255), "R2 arlen", 32'(m_arlen), (bi == 2) ? 127 : 255);
                    chk(m_arsize == 3'd2 && m_arburst == 2'd1, "R2 size/burst",
                        {27'd0, m_arsize, m_arburst}, {27'd0, 3'd2, 2'd1});
                    cur = m_araddr;
                    rem_beats = int'(m_arlen) + 1;
                    bursts++;
                end
            end else begin
                m_arready = 1'b0;
            end
            // stream side
            if (stalled)
                chk(tvalid && {tdata, tuser, tlast} == held, "R7 stall hold",
                    {13'd0, tvalid, tdata, tuser, tlast}, {14'd0, held});
            tready = (tmode == 0) ? 1'b1 : (cyc % 3 != 0);
            if (tvalid && tready) begin
                int col;
                col = beats % LP;
                chk(tdata == pix(exp_base + 32'(4 * col)), "R4 tdata", 32'(tdata), 32'(pix(exp_base + 32'(4 * col))));
                chk(tuser == (beats % (exp_lines * LP) == 0), "R5 tuser", 32'(tuser), 32'(beats % (exp_lines * LP) == 0));
                chk(tlast == (col == LP - 1), "R6 tlast", 32'(tlast), 32'(col == LP - 1));
                chk(rbeats >= (beats / LP + 1) * LP, "R8 line fetched first", rbeats, (beats / LP + 1) * LP);
                beats++;
            end
            stalled = tvalid && !tready;
            held    = {tdata, tuser, tlast};
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        awaddr = a; wdata = v; awvalid = 1'b1; wvalid = 1'b1;
        #1;
        while (!awready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        #1;
        while (!arready_l) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        arvalid = 1'b0;
        v = rdata_l;
    endtask

    task automatic wait_bit(input int b, output logic [31:0] v);
        do begin
            repeat (20) @(negedge clk);
            rd(8'h00, v);
        end while (!v[b]);
    endtask

    task automatic setup(input logic [31:0] b, input int n, input logic [15:0] s, input int tm);
        exp_base = b; exp_lines = n; seed = s; tmode = tm;
        beats = 0; rbeats = 0; bursts = 0;
        wr(8'h18, b);
        wr(8'h10, 32'(n));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tvalid && !m_arvalid, "R10 reset outputs quiet", {30'd0, tvalid, m_arvalid}, 0);
        rd(8'h00, v);
        chk(v == 32'h04, "R10 reset status", v, 32'h04);

        // single frame, three lines, back-pressure on the stream
        setup(32'h1000_0000, 3, 16'd11, 1);
        rd(8'h18, v);
        chk(v == 32'h1000_0000, "R9 base readback", v, 32'h1000_0000);
        rd(8'h10, v);
        chk(v == 32'd3, "R9 lines readback", v, 3);
        wr(8'h00, 32'h01);
        wait_bit(1, v);
        chk(v == 32'h06, "R10 done with idle", v, 32'h06);
        chk(beats == 3 * LP, "R1 beat count", beats, 3 * LP);
        chk(bursts == 9, "R2 burst count", bursts, 9);
        rd(8'h00, v);
        chk(v == 32'h04, "R10 done cleared by read", v, 32'h04);

        // empty frame
        setup(32'h1000_0000, 0, 16'd0, 0);
        wr(8'h00, 32'h01);
        repeat (3) @(negedge clk);
        rd(8'h00, v);
        chk(v == 32'h06, "R12 done at once", v, 32'h06);
        chk(beats == 0 && bursts == 0, "R12 no traffic", beats + bursts, 0);

        // second pattern, full-rate sink
        setup(32'h0000_2000, 2, 16'h1234, 0);
        wr(8'h00, 32'h01);
        wait_bit(1, v);
        chk(beats == 2 * LP, "R1 beat count second frame", beats, 2 * LP);
        chk(bursts == 6, "R3 one burst set per line", bursts, 6);

        // auto-restart, then stop
        setup(32'h0004_0000, 2, 16'd5, 1);
        wr(8'h00, 32'h81);
        repeat (50) @(negedge clk);
        rd(8'h00, v);
        chk((v & 32'h85) == 32'h81, "R11 running with auto bit", v & 32'h85, 32'h81);
        while (beats < 2 * 2 * LP + 100) @(negedge clk);
        wr(8'h00, 32'h00);
        wait_bit(2, v);
        chk(beats == 3 * 2 * LP, "R11 stops after current frame", beats, 3 * 2 * LP);
        chk(bursts == 18, "R11 burst total", bursts, 18);
        chk(v[7] == 1'b0, "R11 auto cleared", 32'(v[7]), 0);
        repeat (1500) @(negedge clk);
        chk(beats == 3 * 2 * LP && bursts == 18, "R11 quiet after stop", beats + bursts, 3 * 2 * LP + 18);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule